// File: doc/BRIEF.md
# Seven-to-one parallel video serializer

This block turns a 21-bit parallel pixel word into three serial lanes plus a forwarded clock. A word is taken in once per pixel-clock period, on the falling edge of that clock. During the following period each lane sends seven bits, one per cycle of a bit clock that runs at exactly seven times the pixel rate. The bit clock's rising edges coincide with those of the pixel clock. The forwarded clock has the pixel frequency and marks the frame: it is high for the first four bit slots and low for the last three, so a receiver can find slot 0 at its rising edge.

An active-low run input acts as the shutdown control. While it is low, every register in both clock domains is cleared and all outputs sit at zero. After it rises, the block finds the phase of the pixel period from its own capture activity. It then waits a parameterised number of pixel periods, the lock interval, before it raises `valid_o` and lets data and the forwarded clock out.

Top module: `ser7_video_tx`

## Requirements
- R1: Lane L (L = 0, 1, 2) carries input bits 7L through 7L+6 and no others.
- R2: The input word is sampled on the falling edge of `pclk_i`. Input changes at any other time have no effect on what is sent.
- R3: `bclk_i` runs at seven times the frequency of `pclk_i` with coincident rising edges. Each lane sends exactly seven bits per pixel period, one per bit-clock cycle.
- R4: While valid, `fwd_clk_o` rises at the start of slot 0, is high for slots 0 to 3 and is low for slots 4 to 6, giving the pixel frequency.
- R5: In slot k (k = 0 to 6), lane L carries input bit 7L+6-k, so the highest bit of each group goes first.
- R6: A word sampled on the falling edge within pixel period n is sent in the slots of period n+1, which start at the next rising edge of `pclk_i`. Words come out in the order they were sampled.
- R7: When `run_i` is low, every register is cleared at once, without waiting for a clock, and `valid_o`, `fwd_clk_o` and `lane_o` are all 0.
- R8: If `run_i` rises in the first half of a pixel period, `valid_o` is still 0 after each of the next LOCK_PERIODS-1 rising edges of `pclk_i` and is 1 right after the LOCK_PERIODS-th one (default 8).
- R9: Once `valid_o` is 1, it stays 1 until `run_i` falls. While it is 0, `fwd_clk_o` and `lane_o` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Pixel-rate clock; the word is sampled on its falling edge |
| bclk_i | input | 1 | Bit clock at seven times the pixel rate, rising-edge aligned |
| run_i | input | 1 | Active-low shutdown: 0 clears everything and silences outputs |
| word_i | input | 21 | Parallel input word |
| lane_o | output | 3 | Serial data lanes, bit L is lane L |
| fwd_clk_o | output | 1 | Forwarded frame clock, high for 4 of 7 slots |
| valid_o | output | 1 | Lock interval has elapsed and outputs carry data |

## Verification
The hardest thing to show from the ports is that the word is taken on the falling edge and not at some other point in the period. The stimulus therefore replaces every word with its complement right after the falling edge that samples it, so a design that samples at the wrong time sends complemented or stale data, and the deserializing scoreboard reports it. The second hard situation is shutdown in the middle of a frame followed by a new lock. The bench drops `run_i` at an arbitrary bit-clock phase, checks at once that every output is zero, and then counts the pixel edges until `valid_o` rises again. A scoreboard holds each word until its frame can be complete. It rebuilds every frame from the slot after the forwarded clock rises, so lane mapping, bit order, latency and the duty pattern are all checked against every word of the walking-one, alternating and random sets.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
    localparam int unsigned LANES      = 3;
    localparam int unsigned SLOTS      = 7;
    localparam int unsigned HIGH_SLOTS = 4;
    localparam int unsigned WORD_W     = LANES * SLOTS;
    localparam int unsigned SLOT_W     = $clog2(SLOTS);

    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
    parameter int unsigned W = 21
) (
    input  logic         pclk_i,
    input  logic         run_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o,
    output logic         tog_o
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         tog;
    } cap_t;

    cap_t cap_d, cap_q;

    // A new word every falling edge; the toggle tells the bit domain a capture happened.
    always_comb begin
        cap_d      = cap_q;
        cap_d.word = word_i;
        cap_d.tog  = ~cap_q.tog;
    end

    always_ff @(negedge pclk_i or negedge run_i) begin
        if (!run_i) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign word_o = cap_q.word;
    assign tog_o  = cap_q.tog;
endmodule

// File: rtl/ser7_sequencer.sv
module ser7_sequencer
    import ser7_pkg::*;
#(
    parameter int unsigned LOCK_PERIODS = 8
) (
    input  logic bclk_i,
    input  logic run_i,
    input  logic tog_i,
    output logic load_o,
    output logic fwd_clk_o,
    output logic valid_o
);
    localparam int unsigned LOCK_W    = $clog2(LOCK_PERIODS + 1);
    localparam slot_t       LAST_SLOT = slot_t'(SLOTS - 1);
    localparam slot_t       HI_SLOTS  = slot_t'(HIGH_SLOTS);
    // The falling-edge capture lands mid-period; its toggle is seen one bit cycle later.
    localparam slot_t       ALIGN_SLOT = slot_t'((SLOTS + 3) / 2);

    typedef logic [LOCK_W-1:0] lock_t;
    localparam lock_t LOCK_LAST = lock_t'(LOCK_PERIODS - 1);
    localparam lock_t LOCK_ONE  = lock_t'(1);
    localparam slot_t SLOT_ONE  = slot_t'(1);

    typedef struct packed {
        logic  tog_s;
        logic  tog_p;
        logic  aligned;
        slot_t slot;
        lock_t lock;
        logic  valid;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tog_edge;
    logic wrap;

    always_comb begin
        seq_d       = seq_q;
        seq_d.tog_s = tog_i;
        seq_d.tog_p = seq_q.tog_s;
        tog_edge    = seq_q.tog_s ^ seq_q.tog_p;
        wrap        = (seq_q.slot == LAST_SLOT);

        if (tog_edge)  seq_d.slot = ALIGN_SLOT;
        else if (wrap) seq_d.slot = '0;
        else           seq_d.slot = seq_q.slot + SLOT_ONE;

        if (tog_edge) seq_d.aligned = 1'b1;

        if (seq_q.aligned && wrap && !seq_q.valid) begin
            seq_d.lock = seq_q.lock + LOCK_ONE;
            if (seq_q.lock == LOCK_LAST) seq_d.valid = 1'b1;
        end
    end

    always_ff @(posedge bclk_i or negedge run_i) begin
        if (!run_i) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign load_o    = wrap;
    assign fwd_clk_o = seq_q.valid && (seq_q.slot < HI_SLOTS);
    assign valid_o   = seq_q.valid;

    // R3: once phase is known, the slot counter steps by one until the last slot
    p_slot_step_r3: assert property (@(posedge bclk_i) disable iff (!run_i)
        (seq_q.aligned && seq_q.slot != LAST_SLOT) |=> (seq_q.slot == $past(seq_q.slot) + SLOT_ONE));

    // R9: valid never drops while running
    p_valid_sticky_r9: assert property (@(posedge bclk_i) disable iff (!run_i)
        seq_q.valid |=> seq_q.valid);

    // R8: lock cannot complete before the period phase is found
    p_lock_after_align_r8: assert property (@(posedge bclk_i) disable iff (!run_i)
        !seq_q.aligned |-> !seq_q.valid);
endmodule

// File: rtl/ser7_lane.sv
module ser7_lane
    import ser7_pkg::*;
(
    input  logic             bclk_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [SLOTS-1:0] par_i,
    output logic             ser_o
);
    typedef struct packed {
        logic [SLOTS-1:0] sh;
    } lane_t;

    lane_t lane_d, lane_q;

    // Highest bit leaves first: shift toward the top.
    always_comb begin
        lane_d = lane_q;
        if (load_i) lane_d.sh = par_i;
        else        lane_d.sh = {lane_q.sh[SLOTS-2:0], 1'b0};
    end

    always_ff @(posedge bclk_i or negedge run_i) begin
        if (!run_i) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign ser_o = lane_q.sh[SLOTS-1];
endmodule

// File: rtl/ser7_video_tx.sv
module ser7_video_tx
    import ser7_pkg::*;
#(
    parameter int unsigned LOCK_PERIODS = 8
) (
    input  logic              pclk_i,
    input  logic              bclk_i,
    input  logic              run_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [LANES-1:0]  lane_o,
    output logic              fwd_clk_o,
    output logic              valid_o
);
    logic [WORD_W-1:0] cap_word;
    logic              cap_tog;
    logic              load;
    logic              valid;
    logic [LANES-1:0]  ser;

    ser7_capture #(.W(WORD_W)) i_capture (
        .pclk_i (pclk_i),
        .run_i  (run_i),
        .word_i (word_i),
        .word_o (cap_word),
        .tog_o  (cap_tog)
    );

    ser7_sequencer #(.LOCK_PERIODS(LOCK_PERIODS)) i_sequencer (
        .bclk_i    (bclk_i),
        .run_i     (run_i),
        .tog_i     (cap_tog),
        .load_o    (load),
        .fwd_clk_o (fwd_clk_o),
        .valid_o   (valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ser7_lane i_lane (
            .bclk_i (bclk_i),
            .run_i  (run_i),
            .load_i (load),
            .par_i  (cap_word[g*SLOTS +: SLOTS]),
            .ser_o  (ser[g])
        );
        assign lane_o[g] = valid & ser[g];
    end

    assign valid_o = valid;

    // R4: the frame clock rises only in the slot right after a load
    p_fwd_rise_load_r4: assert property (@(posedge bclk_i) disable iff (!run_i)
        $rose(fwd_clk_o) |-> $past(load));

    // R4: the frame clock has been high for four slots when it falls
    p_fwd_width_r4: assert property (@(posedge bclk_i) disable iff (!run_i)
        $fell(fwd_clk_o) |-> ($past(fwd_clk_o, 2) && $past(fwd_clk_o, 3) && $past(fwd_clk_o, 4)));
endmodule

// File: tb/test_ser7_video_tx.sv
module test_ser7_video_tx;
    localparam int LOCK = 8;

    logic        bclk = 1'b0;
    logic        pclk = 1'b0;
    logic        run  = 1'b0;
    logic [20:0] word = '0;
    logic [2:0]  lane;
    logic        fwd;
    logic        valid;

    ser7_video_tx #(.LOCK_PERIODS(LOCK)) i_ser7_video_tx (
        .pclk_i    (pclk),
        .bclk_i    (bclk),
        .run_i     (run),
        .word_i    (word),
        .lane_o    (lane),
        .fwd_clk_o (fwd),
        .valid_o   (valid)
    );

    // 250 MHz bit clock; pixel clock seven times slower, rising edges coincide.
    always #2  bclk = ~bclk;
    always #14 pclk = ~pclk;

    int          n_chk  = 0;
    int          n_fail = 0;
    int          n_push = 0;
    int          n_cmp  = 0;
    logic [20:0] exp_q[$];
    logic [20:0] prev_w;
    bit          have_prev = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: rebuild each frame starting at the forwarded-clock rise.
    int          idx = -1;
    logic        prev_f = 1'b0;
    logic [20:0] got;
    logic [6:0]  fpat;
    logic [20:0] e;
    always @(negedge bclk) begin
        if (!valid) begin
            idx = -1;
        end else begin
            if (!prev_f && fwd) idx = 0;
            if (idx >= 0) begin
                for (int l = 0; l < 3; l++) got[7*l + 6 - idx] = lane[l];
                fpat[6 - idx] = fwd;
                idx++;
                if (idx == 7) begin
                    if (exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        n_cmp++;
                        check(got == e, "R1 R2 R5 R6", "frame word", {11'd0, got}, {11'd0, e});
                        check(fpat == 7'b1111000, "R3 R4", "fwd pattern", {25'd0, fpat}, 32'h78);
                    end
                    idx = -1;
                end
            end
        end
        prev_f = fwd;
    end

    task automatic send(input logic [20:0] w);
        @(posedge pclk);
        #1;
        if (have_prev) begin exp_q.push_back(prev_w); n_push++; end
        word = w;
        prev_w = w;
        have_prev = 1;
        @(negedge pclk);
        #1;
        word = ~w;                          // R2: changes after the sampling edge are ignored
    endtask

    task automatic flush();
        @(posedge pclk);
        #1;
        if (have_prev) begin exp_q.push_back(prev_w); n_push++; end
        have_prev = 0;
        for (int i = 0; i < 4; i++) @(posedge pclk);
        check(exp_q.size() == 0, "R6", "words left unsent", exp_q.size(), 0);
        check(n_cmp == n_push, "R6", "frames compared", n_cmp, n_push);
    endtask

    task automatic release_and_lock();
        @(posedge pclk);
        #1;
        run = 1'b1;
        for (int i = 1; i < LOCK; i++) begin
            @(posedge pclk);
            #1;
            check(valid == 1'b0, "R8", "valid early", valid, 0);
            check(fwd == 1'b0 && lane == 3'b000, "R9", "outputs before lock", {fwd, lane}, 0);
        end
        @(posedge pclk);
        #1;
        check(valid == 1'b1, "R8", "valid at lock", valid, 1);
        check(fwd == 1'b1, "R4", "fwd high in slot 0", fwd, 1);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        word = 21'h1ABCDE;
        repeat (5) @(posedge pclk);
        #3;
        check(valid == 1'b0 && fwd == 1'b0 && lane == 3'b000, "R7", "reset outputs",
              {valid, fwd, lane}, 0);

        release_and_lock();

        send(21'h000000);
        send(21'h1FFFFF);
        for (int b = 0; b < 21; b++) send(21'(1) << b);   // R1 R5 walking one
        send(21'h155555);
        send(21'h0AAAAA);
        for (int i = 0; i < 40; i++) send(21'($urandom));
        flush();

        // R7: shutdown at an odd bit-clock phase, mid-frame
        send(21'h123456);
        #9;
        run = 1'b0;
        #1;
        check(valid == 1'b0 && fwd == 1'b0 && lane == 3'b000, "R7", "outputs on shutdown",
              {valid, fwd, lane}, 0);
        have_prev = 0;
        repeat (3) @(posedge pclk);
        #5;
        check(valid == 1'b0 && fwd == 1'b0 && lane == 3'b000, "R7", "outputs held off",
              {valid, fwd, lane}, 0);

        release_and_lock();
        for (int i = 0; i < 30; i++) send(21'($urandom));
        send(21'h100001);
        flush();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule